// File: doc/BRIEF.md
# Chunked Transfer Sequencer with FIFO Flow Control

This block sequences one data transfer between a register-mapped FIFO window on the host side and a byte stream on the card side. Software writes a single control word that carries a byte count, a direction, a transfer width and two stored mode flags, with the top bit set to launch the transfer. From then on the block counts down the bytes the host moves through the FIFO, keeps an occupancy count of the FIFO, and grants or refuses each host and card strobe so the FIFO never overflows or underflows.

The block emits two one-cycle events for an interrupt controller. The buffer event tells the host that a full chunk can be moved: a chunk of data waiting on a read, or a chunk of free space on a write. It also fires for the short final piece of a read. The done event marks the end of the programmed count. A transfer can be stopped early by writing the control word with the launch bit clear, or by the error input. The FIFO storage and the card bus waveforms live outside this block.

Top module: `cfx_xfer_ctrl`

## Requirements
- R1: After reset the control readback is 0, the FIFO level is 0 and both events are low.
- R2: A control write with bit 31 set starts a transfer. It loads the remaining count from bits 17:0 and clears the FIFO level to 0. Readback then shows bit 31 = 1, bit 30 = direction (1 write, 0 read), bit 28 = DMA flag, bit 25 = width (1 is 16-bit, 0 is 8-bit), bit 24 = no-increment flag and bits 17:0 = remaining count. All other bits read 0.
- R3: A start with a count of 0 raises the done event in the cycle after the write, and bit 31 reads 0.
- R4: While a transfer runs, a host strobe is acknowledged if the remaining count is non-zero. On a write the FIFO must have room for the step. On a read the FIFO must hold the step. The step is 2 bytes in 16-bit mode when at least 2 bytes remain, and 1 byte otherwise. Each acknowledged strobe lowers the remaining count by the step.
- R5: While a transfer runs, a card strobe is acknowledged when the FIFO has data to give (write) or when it has room that the remaining count still allows (read). The step is 2 in 16-bit mode when that amount is at least 2, and 1 otherwise. The level moves up by host pushes on writes and card pushes on reads, and down by the other side.
- R6: On a write, the buffer event is a one-cycle pulse each time the free space goes from below CHUNK bytes to CHUNK bytes or more.
- R7: On a read, the buffer event is a one-cycle pulse each time this condition becomes true: the level is at least CHUNK, or the level is non-zero and equals the remaining count (the final partial chunk).
- R8: The done event is a one-cycle pulse in the cycle after the host strobe that moves the last bytes. Bit 31 reads 0 in that same cycle.
- R9: A control write with bit 31 clear stops the transfer without a done event. It keeps the remaining count and the level, and no later strobe is acknowledged.
- R10: The error input stops the transfer without a done event. A control write in the same cycle is dropped.
- R11: The level never exceeds DEPTH. During a read it never exceeds the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| xfer_err | input | 1 | Transfer error, stops the transfer |
| host_stb | input | 1 | Host side FIFO push (write) or pop (read) request |
| host_ack | output | 1 | Host strobe accepted this cycle |
| card_stb | input | 1 | Card side byte transfer request |
| card_ack | output | 1 | Card strobe accepted this cycle |
| fifo_level | output | OCC_W | FIFO occupancy in bytes |
| evt_buf_avail | output | 1 | Chunk ready event pulse |
| evt_xfer_done | output | 1 | Transfer complete event pulse |

## Verification
The bench builds the block with CHUNK and DEPTH set to 64 bytes and the full 18-bit count field. A transfer of a few hundred bytes therefore crosses several chunk boundaries and ends with a partial chunk in a few hundred cycles, so dozens of transfers fit in one run. Random counts, directions and widths, together with random strobe patterns on both sides, exercise full, empty and concurrent FIFO states. Directed cases cover a zero count, a 5-byte partial read, odd counts in 16-bit mode, and aborts by control write and by the error input.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  localparam int START_BIT = 31;
  localparam int DIR_BIT   = 30;
  localparam int DMA_BIT   = 28;
  localparam int WIDE_BIT  = 25;
  localparam int NOINC_BIT = 24;

  typedef struct packed {
    logic dir_wr;
    logic dma;
    logic wide;
    logic noinc;
  } cfx_cfg_t;
endpackage

// File: rtl/cfx_ctl_reg.sv
module cfx_ctl_reg
  import cfx_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [31:0]      wdata,
  input  logic             err,
  input  logic             host_fire,
  input  logic [1:0]       hstep,
  output logic             active,
  output logic [CNT_W-1:0] rem,
  output cfx_cfg_t         cfg,
  output logic             done
);
  logic             active_n;
  logic [CNT_W-1:0] rem_n;
  cfx_cfg_t         cfg_n;
  logic             done_n;
  logic             en;
  logic [CNT_W-1:0] step_e;

  assign step_e = {{(CNT_W-2){1'b0}}, hstep};
  assign en     = err | we | (active & host_fire);

  always_comb begin
    active_n = active;
    rem_n    = rem;
    cfg_n    = cfg;
    done_n   = 1'b0;
    if (err) begin
      active_n = 1'b0;
    end else if (we) begin
      cfg_n.dir_wr = wdata[DIR_BIT];
      cfg_n.dma    = wdata[DMA_BIT];
      cfg_n.wide   = wdata[WIDE_BIT];
      cfg_n.noinc  = wdata[NOINC_BIT];
      if (wdata[START_BIT]) begin
        rem_n = wdata[CNT_W-1:0];
        if (wdata[CNT_W-1:0] == '0) begin
          done_n   = 1'b1;
          active_n = 1'b0;
        end else begin
          active_n = 1'b1;
        end
      end else begin
        active_n = 1'b0;
      end
    end else if (active && host_fire) begin
      rem_n = rem - step_e;
      if (rem == step_e) begin
        done_n   = 1'b1;
        active_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem    <= '0;
      cfg    <= '0;
    end else if (en) begin
      active <= active_n;
      rem    <= rem_n;
      cfg    <= cfg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= done_n;
  end

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active); // R8
  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !we) |=> $stable(rem)); // R9
endmodule

// File: rtl/cfx_occ.sv
module cfx_occ #(
  parameter int CNT_W = 18,
  parameter int DEPTH = 512,
  parameter int OCC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             hold,
  input  logic             active,
  input  logic             dir_wr,
  input  logic             wide,
  input  logic [CNT_W-1:0] rem,
  input  logic             host_stb,
  input  logic             card_stb,
  output logic             host_ack,
  output logic             card_ack,
  output logic [1:0]       hstep,
  output logic [OCC_W-1:0] occ
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] occ_e, free_e, rd_room, space, hstep_e, cstep_e;
  logic [1:0]       cstep;
  logic             h_ok, c_ok;
  logic [OCC_W-1:0] inc, dec, occ_n;
  logic             en;

  assign occ_e   = CNT_W'(occ);
  assign free_e  = DEPTH_C - occ_e;
  assign rd_room = rem - occ_e;
  assign hstep   = (wide && rem >= CNT_W'(2)) ? 2'd2 : 2'd1;
  assign hstep_e = CNT_W'(hstep);

  always_comb begin
    if (dir_wr)                space = occ_e;
    else if (free_e < rd_room) space = free_e;
    else                       space = rd_room;
  end

  assign cstep   = (wide && space >= CNT_W'(2)) ? 2'd2 : 2'd1;
  assign cstep_e = CNT_W'(cstep);

  assign h_ok = active && !hold && (rem != '0) &&
                (dir_wr ? (free_e >= hstep_e) : (occ_e >= hstep_e));
  assign c_ok = active && !hold && (space >= cstep_e);

  assign host_ack = host_stb & h_ok;
  assign card_ack = card_stb & c_ok;

  always_comb begin
    inc = '0;
    dec = '0;
    if (dir_wr) begin
      if (host_ack) inc = OCC_W'(hstep);
      if (card_ack) dec = OCC_W'(cstep);
    end else begin
      if (card_ack) inc = OCC_W'(cstep);
      if (host_ack) dec = OCC_W'(hstep);
    end
    occ_n = flush ? '0 : (occ + inc - dec);
  end

  assign en = flush | host_ack | card_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  occ <= '0;
    else if (en) occ <= occ_n;
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_e <= DEPTH_C); // R11
  AST_READ_LEVEL_LE_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dir_wr) |-> (occ_e <= rem)); // R11
endmodule

// File: rtl/cfx_avail.sv
module cfx_avail #(
  parameter int CNT_W = 18,
  parameter int DEPTH = 512,
  parameter int CHUNK = 512,
  parameter int OCC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             dir_wr,
  input  logic [OCC_W-1:0] occ,
  input  logic [CNT_W-1:0] rem,
  output logic             evt
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CHUNK_C = CNT_W'(CHUNK);

  logic [CNT_W-1:0] occ_e;
  logic             wr_cond, rd_cond, cond, cond_q;

  assign occ_e   = CNT_W'(occ);
  assign wr_cond = (DEPTH_C - occ_e) >= CHUNK_C;
  assign rd_cond = (occ_e >= CHUNK_C) || ((occ_e != '0) && (occ_e == rem));
  assign cond    = active && (dir_wr ? wr_cond : rd_cond);
  assign evt     = cond & ~cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  AST_AVAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R6
endmodule

// File: rtl/cfx_xfer_ctrl.sv
module cfx_xfer_ctrl
  import cfx_pkg::*;
#(
  parameter int CNT_W = 18,
  parameter int CHUNK = 512,
  parameter int DEPTH = 512,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  output logic [31:0]      ctl_rdata,
  input  logic             xfer_err,
  input  logic             host_stb,
  output logic             host_ack,
  input  logic             card_stb,
  output logic             card_ack,
  output logic [OCC_W-1:0] fifo_level,
  output logic             evt_buf_avail,
  output logic             evt_xfer_done
);
  logic             active;
  logic [CNT_W-1:0] rem;
  cfx_cfg_t         cfg;
  logic [1:0]       hstep;
  logic             hold, flush;

  assign hold  = ctl_we | xfer_err;
  assign flush = ctl_we & ctl_wdata[START_BIT] & ~xfer_err;

  cfx_ctl_reg #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctl_we),
    .wdata     (ctl_wdata),
    .err       (xfer_err),
    .host_fire (host_ack),
    .hstep     (hstep),
    .active    (active),
    .rem       (rem),
    .cfg       (cfg),
    .done      (evt_xfer_done)
  );

  cfx_occ #(.CNT_W(CNT_W), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .hold     (hold),
    .active   (active),
    .dir_wr   (cfg.dir_wr),
    .wide     (cfg.wide),
    .rem      (rem),
    .host_stb (host_stb),
    .card_stb (card_stb),
    .host_ack (host_ack),
    .card_ack (card_ack),
    .hstep    (hstep),
    .occ      (fifo_level)
  );

  cfx_avail #(.CNT_W(CNT_W), .DEPTH(DEPTH), .CHUNK(CHUNK), .OCC_W(OCC_W)) u_avail (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .dir_wr (cfg.dir_wr),
    .occ    (fifo_level),
    .rem    (rem),
    .evt    (evt_buf_avail)
  );

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[START_BIT] = active;
    ctl_rdata[DIR_BIT]   = cfg.dir_wr;
    ctl_rdata[DMA_BIT]   = cfg.dma;
    ctl_rdata[WIDE_BIT]  = cfg.wide;
    ctl_rdata[NOINC_BIT] = cfg.noinc;
    ctl_rdata[CNT_W-1:0] = rem;
  end
endmodule

// File: tb/cfx_xfer_ctrl_tb.sv
module cfx_xfer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 18;
  localparam int CHUNK = 64;
  localparam int DEPTH = 64;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic clk, rst_n, ctl_we, xfer_err, host_stb, card_stb;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic host_ack, card_ack, evt_buf_avail, evt_xfer_done;
  logic [OCC_W-1:0] fifo_level;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int m_active, m_dir, m_dma, m_wide, m_noinc, m_rem, m_occ, m_condq, m_done;

  cfx_xfer_ctrl #(.CNT_W(CNT_W), .CHUNK(CHUNK), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .xfer_err(xfer_err), .host_stb(host_stb),
    .host_ack(host_ack), .card_stb(card_stb), .card_ack(card_ack),
    .fifo_level(fifo_level), .evt_buf_avail(evt_buf_avail),
    .evt_xfer_done(evt_xfer_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctl_word(input int start, input int dir, input int dma,
                                           input int wide, input int noinc, input int cnt);
    logic [31:0] w;
    w = '0;
    w[31] = start[0]; w[30] = dir[0]; w[28] = dma[0];
    w[25] = wide[0];  w[24] = noinc[0];
    w[17:0] = cnt[17:0];
    return w;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // One cycle: drive at negedge, compare against model, advance model to next edge.
  task automatic step(input bit we, input logic [31:0] wd, input bit err, input bit hs, input bit cs);
    int hold, hstep, space, cstep, h_ok, c_ok, hack, cack, cond, avail, w;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; xfer_err = err; host_stb = hs; card_stb = cs;
    #1;
    hold  = we | err;
    hstep = (m_wide != 0 && m_rem >= 2) ? 2 : 1;
    h_ok  = (m_active != 0 && hold == 0 && m_rem != 0 &&
             (m_dir != 0 ? (DEPTH - m_occ) >= hstep : m_occ >= hstep)) ? 1 : 0;
    space = (m_dir != 0) ? m_occ : imin(DEPTH - m_occ, m_rem - m_occ);
    cstep = (m_wide != 0 && space >= 2) ? 2 : 1;
    c_ok  = (m_active != 0 && hold == 0 && space >= cstep) ? 1 : 0;
    hack  = hs & h_ok;
    cack  = cs & c_ok;
    cond  = (m_active != 0 && (m_dir != 0 ? (DEPTH - m_occ) >= CHUNK :
             (m_occ >= CHUNK || (m_occ != 0 && m_occ == m_rem)))) ? 1 : 0;
    avail = (cond != 0 && m_condq == 0) ? 1 : 0;
    chk(ctl_rdata, ctl_word(m_active, m_dir, m_dma, m_wide, m_noinc, m_rem), "R4 readback");
    chk(32'(fifo_level), 32'(m_occ), "R5 level");
    chk(32'(evt_xfer_done), 32'(m_done), "R8 done");
    if (m_dir != 0) chk(32'(evt_buf_avail), 32'(avail), "R6 buf_avail write");
    else            chk(32'(evt_buf_avail), 32'(avail), "R7 buf_avail read");
    chk(32'(host_ack), 32'(hack), "R4 host_ack");
    chk(32'(card_ack), 32'(cack), "R5 card_ack");
    m_condq = cond;
    m_done  = 0;
    if (err) begin
      m_active = 0;
    end else if (we) begin
      m_dir = wd[30]; m_dma = wd[28]; m_wide = wd[25]; m_noinc = wd[24];
      if (wd[31]) begin
        m_rem = int'(wd[17:0]); m_occ = 0;
        if (m_rem == 0) begin m_done = 1; m_active = 0; end
        else m_active = 1;
      end else m_active = 0;
    end else if (m_active != 0) begin
      w = 0;
      if (m_dir != 0) w = (hack ? hstep : 0) - (cack ? cstep : 0);
      else            w = (cack ? cstep : 0) - (hack ? hstep : 0);
      m_occ = m_occ + w;
      if (hack) begin
        if (m_rem == hstep) begin m_done = 1; m_active = 0; end
        m_rem = m_rem - hstep;
      end
    end
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_c0de);
    ctl_we = 0; ctl_wdata = 0; xfer_err = 0; host_stb = 0; card_stb = 0;
    m_active = 0; m_dir = 0; m_dma = 0; m_wide = 0; m_noinc = 0;
    m_rem = 0; m_occ = 0; m_condq = 0; m_done = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ctl_rdata, 32'h0, "R1 reset rdata");
    chk(32'(fifo_level), 32'h0, "R1 reset level");
    chk(32'(evt_buf_avail | evt_xfer_done), 32'h0, "R1 reset events");
    rst_n = 1;

    // R3: zero count completes at once
    step(1, ctl_word(1, 1, 0, 0, 0, 0), 0, 0, 0);
    idle();
    chk(32'(evt_xfer_done), 32'h1, "R3 zero-count done");
    chk(32'(ctl_rdata[31]), 32'h0, "R3 zero-count start clear");

    // R2: config bits read back at their positions
    step(1, ctl_word(1, 1, 1, 1, 1, 16'h1234), 0, 0, 0);
    idle();
    chk(ctl_rdata, 32'hD300_1234, "R2 readback after start");
    chk(32'(fifo_level), 32'h0, "R2 level flushed");
    step(1, ctl_word(0, 1, 1, 1, 1, 0), 0, 0, 0);

    // R7: 5-byte partial read
    step(1, ctl_word(1, 0, 0, 0, 0, 5), 0, 0, 0);
    idle();
    chk(32'(evt_buf_avail), 32'h0, "R7 no event while empty");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1);
    idle();
    chk(32'(fifo_level), 32'd5, "R5 level after 5 card bytes");
    chk(32'(evt_buf_avail), 32'h1, "R7 partial chunk event");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0);
    idle();
    chk(32'(evt_xfer_done), 32'h1, "R8 done after last pop");
    chk(32'(ctl_rdata[31]), 32'h0, "R8 start cleared");

    // R6 and R9: write transfer aborted by control write
    step(1, ctl_word(1, 1, 0, 0, 0, 100), 0, 0, 0);
    idle();
    chk(32'(evt_buf_avail), 32'h1, "R6 free chunk event at start");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
    step(1, ctl_word(0, 1, 0, 0, 0, 0), 0, 0, 0);
    idle();
    chk(32'(ctl_rdata[17:0]), 32'd97, "R9 remaining kept");
    chk(32'(ctl_rdata[31]), 32'h0, "R9 start cleared");
    chk(32'(evt_xfer_done), 32'h0, "R9 no done on abort");
    step(0, 0, 0, 1, 1);
    chk(32'(host_ack | card_ack), 32'h0, "R9 strobes ignored after abort");
    idle();
    chk(32'(fifo_level), 32'd3, "R9 level kept");

    // R10: error abort, with a write in the same cycle dropped
    step(1, ctl_word(1, 0, 0, 0, 0, 50), 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(1, ctl_word(1, 1, 0, 0, 0, 7), 1, 0, 0);
    idle();
    chk(32'(ctl_rdata[31]), 32'h0, "R10 start cleared by error");
    chk(32'(ctl_rdata[17:0]), 32'd50, "R10 write dropped");
    chk(32'(evt_xfer_done), 32'h0, "R10 no done on error");

    // R4: odd count in 16-bit mode
    step(1, ctl_word(1, 1, 0, 1, 0, 3), 0, 0, 0);
    step(0, 0, 0, 1, 0);
    idle();
    chk(32'(ctl_rdata[17:0]), 32'd1, "R4 wide step of 2");
    step(0, 0, 0, 1, 0);
    idle();
    chk(32'(evt_xfer_done), 32'h1, "R4 wide tail byte completes");

    // Random transfers
    for (int t = 0; t < 60; t++) begin
      int dir, wide, cnt, n;
      dir  = $urandom % 2;
      wide = $urandom % 2;
      cnt  = (($urandom % 10) == 0) ? 0 : 1 + ($urandom % 400);
      step(1, ctl_word(1, dir, $urandom % 2, wide, $urandom % 2, cnt), 0, 0, 0);
      n = 0;
      while (m_active != 0 && n < 4000) begin
        int r;
        r = $urandom % 1000;
        if (r == 0)      step(0, 0, 1, 0, 0);
        else if (r == 1) step(1, ctl_word(0, dir, 0, wide, 0, 0), 0, 0, 0);
        else step(0, 0, 0, ($urandom % 10) < 7, ($urandom % 10) < 7);
        n++;
      end
      idle();
      idle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule